// File: doc/BRIEF.md
# Pseudo-Ternary Line Coder and Violation Detector

This block sits between the bit-serial data path of a 192 kbit/s full-duplex subscriber-loop link and its analog line driver and slicer. On the transmit side it takes one data bit per line cell and drives two polarity outputs, one for a positive pulse and one for a negative pulse. A binary zero is sent as a mark. A mark is a full-cell pulse of either polarity, and the pulse does not return to zero inside the cell. A binary one is sent as a cell with no pulse. Successive marks alternate in polarity. On request, a zero can be sent as a deliberate violation, which repeats the previous polarity.

On the receive side it samples the sliced positive and negative indications once per cell and recovers the bit. It flags every mark whose polarity matches the previous mark. It reports a cell in which both slicer outputs are active as a line error. Cell timing comes from two strobes, one for each direction, produced by the link timing logic.

The transmit input is a valid/ready stream whose ready signal is the transmit cell strobe. A bit is taken only in a cycle where both valid and ready are high. The source must hold the bit, valid and the violation request until ready arrives. A cell strobe that finds valid low sends an idle cell. The receive output is a valid-only stream because the line cannot be stalled: valid pulses for one cycle per cell, and the sink must take it then. The bit and the flags then stay unchanged until the next cell.

Top module: `ptern_line_codec`

## Requirements
- R1: `tx_ready` is high exactly in cycles where `tx_tick` is high. The line outputs change only in the cycle after a `tx_tick`, and they then hold for the whole cell.
- R2: An accepted bit of value 1 gives a cell with both `line_pos_o` and `line_neg_o` low.
- R3: An accepted bit of value 0 gives a mark, with exactly one line output high. The first mark after reset is positive (`line_pos_o`=1). Each later mark takes the opposite polarity of the previous mark. Cells with no pulse between marks do not break this alternation.
- R4: With `tx_force_viol`=1 on an accepted 0 bit, the mark repeats the polarity of the previous mark. On a 1 bit the request has no effect. On the first mark after reset the mark is still positive.
- R5: A `tx_tick` with `tx_valid` low sends an idle cell with both outputs low, and it leaves the polarity memory unchanged.
- R6: `line_pos_o` and `line_neg_o` are never high together.
- R7: One cycle after each `rx_tick`, `rx_valid` is high for exactly one cycle, and `rx_bit` holds the decoded bit: 0 when exactly one of `rx_pos` or `rx_neg` was high, and 1 when neither was high.
- R8: `rx_viol` is 1 for a cell whose single mark has the same polarity as the previous mark. The flag holds until the next `rx_tick`. Every mark, violating or not, becomes the new previous mark.
- R9: After reset the first received mark is never flagged, whatever its polarity.
- R10: A receive cell with both `rx_pos` and `rx_neg` high sets `rx_line_err`, decodes as `rx_bit`=0 with `rx_viol`=0, and leaves the previous-mark polarity unchanged.
- R11: During and right after reset, the line outputs, `rx_valid`, `rx_viol` and `rx_line_err` are 0, and `rx_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_tick | input | 1 | Transmit cell strobe |
| tx_valid | input | 1 | Transmit bit present |
| tx_ready | output | 1 | Transmit bit taken this cycle |
| tx_bit | input | 1 | Transmit data bit |
| tx_force_viol | input | 1 | Send this zero with repeated polarity |
| line_pos_o | output | 1 | Positive pulse drive |
| line_neg_o | output | 1 | Negative pulse drive |
| rx_tick | input | 1 | Receive cell sample strobe |
| rx_pos | input | 1 | Sliced positive mark |
| rx_neg | input | 1 | Sliced negative mark |
| rx_valid | output | 1 | Decoded cell available (one cycle) |
| rx_bit | output | 1 | Decoded bit |
| rx_viol | output | 1 | Polarity violation in this cell |
| rx_line_err | output | 1 | Both polarities seen in this cell |

## Verification
Random transmit streams with a mix of zeros, ones, idle cells and violation requests, sent with uneven gaps between strobes, separate correct alternation from a polarity memory that resets on ones or idle cells. They also show whether forced repeats land on the right polarity. Random receive patterns that include doubled marks and both-active cells show whether the tracker follows violating marks and whether it is left untouched by line errors. Directed sequences cover the first mark after reset in each direction and a forced violation on the very first mark. They also cover a second reset that must clear the receive history.

// File: rtl/ptern_pkg.sv
package ptern_pkg;
  typedef enum logic {POL_NEG = 1'b0, POL_POS = 1'b1} pol_t;
  localparam int CELL_W = 1;
endpackage

// File: rtl/ptern_tx.sv
module ptern_tx
  import ptern_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cell_stb,
  input  logic bit_vld,
  input  logic bit_val,
  input  logic force_rep,
  output logic drv_pos,
  output logic drv_neg
);
  pol_t last_q;
  logic sent_q;
  pol_t next_pol;
  logic mark;

  assign mark = bit_vld && !bit_val;

  always_comb begin
    if (!sent_q)        next_pol = POL_POS;
    else if (force_rep) next_pol = last_q;
    else                next_pol = (last_q == POL_POS) ? POL_NEG : POL_POS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv_pos <= 1'b0;
      drv_neg <= 1'b0;
      last_q  <= POL_NEG;
      sent_q  <= 1'b0;
    end else if (cell_stb) begin
      if (mark) begin
        drv_pos <= (next_pol == POL_POS);
        drv_neg <= (next_pol == POL_NEG);
        last_q  <= next_pol;
        sent_q  <= 1'b1;
      end else begin
        drv_pos <= 1'b0;
        drv_neg <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ptern_rx.sv
module ptern_rx
  import ptern_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cell_stb,
  input  logic smp_pos,
  input  logic smp_neg,
  output logic out_vld,
  output logic out_bit,
  output logic out_viol,
  output logic out_err
);
  pol_t prev_q;
  logic seen_q;
  logic single;
  logic both;
  pol_t cur_pol;

  assign single  = smp_pos ^ smp_neg;
  assign both    = smp_pos & smp_neg;
  assign cur_pol = smp_pos ? POL_POS : POL_NEG;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_bit  <= 1'b1;
      out_viol <= 1'b0;
      out_err  <= 1'b0;
      prev_q   <= POL_NEG;
      seen_q   <= 1'b0;
    end else begin
      out_vld <= cell_stb;
      if (cell_stb) begin
        out_bit  <= !(single || both);
        out_err  <= both;
        out_viol <= single && seen_q && (cur_pol == prev_q);
        if (single) begin
          prev_q <= cur_pol;
          seen_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ptern_line_codec.sv
module ptern_line_codec
  import ptern_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tx_tick,
  input  logic tx_valid,
  output logic tx_ready,
  input  logic tx_bit,
  input  logic tx_force_viol,
  output logic line_pos_o,
  output logic line_neg_o,
  input  logic rx_tick,
  input  logic rx_pos,
  input  logic rx_neg,
  output logic rx_valid,
  output logic rx_bit,
  output logic rx_viol,
  output logic rx_line_err
);
  assign tx_ready = tx_tick;

  ptern_tx u_tx (
    .clk(clk), .rst_n(rst_n), .cell_stb(tx_tick), .bit_vld(tx_valid),
    .bit_val(tx_bit), .force_rep(tx_force_viol),
    .drv_pos(line_pos_o), .drv_neg(line_neg_o)
  );

  ptern_rx u_rx (
    .clk(clk), .rst_n(rst_n), .cell_stb(rx_tick), .smp_pos(rx_pos),
    .smp_neg(rx_neg), .out_vld(rx_valid), .out_bit(rx_bit),
    .out_viol(rx_viol), .out_err(rx_line_err)
  );
endmodule

// File: rtl/ptern_codec_chk.sv
module ptern_codec_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_tick,
  input logic tx_valid,
  input logic tx_bit,
  input logic line_pos_o,
  input logic line_neg_o,
  input logic rx_tick,
  input logic rx_pos,
  input logic rx_neg,
  input logic rx_valid,
  input logic rx_bit,
  input logic rx_viol,
  input logic rx_line_err
);
  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_pos_o && line_neg_o));
  p_tx_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_tick |=> $stable(line_pos_o) && $stable(line_neg_o));
  p_tx_space_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tick && tx_valid && tx_bit |=> !line_pos_o && !line_neg_o);
  p_tx_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tick && tx_valid && !tx_bit |=> line_pos_o ^ line_neg_o);
  p_tx_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tick && !tx_valid |=> !line_pos_o && !line_neg_o);
  p_rx_vld_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_tick |=> rx_valid);
  p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_tick |=> $stable(rx_viol) && !rx_valid);
  p_rx_both_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_tick && rx_pos && rx_neg |=> rx_line_err && !rx_bit && !rx_viol);
endmodule

bind ptern_line_codec ptern_codec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_tick(tx_tick), .tx_valid(tx_valid),
  .tx_bit(tx_bit), .line_pos_o(line_pos_o), .line_neg_o(line_neg_o),
  .rx_tick(rx_tick), .rx_pos(rx_pos), .rx_neg(rx_neg), .rx_valid(rx_valid),
  .rx_bit(rx_bit), .rx_viol(rx_viol), .rx_line_err(rx_line_err)
);

// File: tb/sim_ptern_line_codec.sv
module sim_ptern_line_codec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_tick = 1'b0, tx_valid = 1'b0, tx_bit = 1'b1, tx_force_viol = 1'b0;
  logic rx_tick = 1'b0, rx_pos = 1'b0, rx_neg = 1'b0;
  logic tx_ready, line_pos_o, line_neg_o, rx_valid, rx_bit, rx_viol, rx_line_err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic m_tx_last, m_tx_sent, m_pos, m_neg;
  logic m_rx_last, m_rx_seen, m_bit, m_viol, m_err;

  always #10 clk = ~clk;

  ptern_line_codec u0 (
    .clk(clk), .rst_n(rst_n), .tx_tick(tx_tick), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_bit(tx_bit), .tx_force_viol(tx_force_viol),
    .line_pos_o(line_pos_o), .line_neg_o(line_neg_o), .rx_tick(rx_tick),
    .rx_pos(rx_pos), .rx_neg(rx_neg), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .rx_viol(rx_viol), .rx_line_err(rx_line_err)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tx_tick = 0; rx_tick = 0;
    repeat (3) @(negedge clk);
    chk("R11 reset outputs", {line_pos_o, line_neg_o, rx_valid, rx_viol},
        4'b0000);
    chk("R11 reset rx", {2'b00, rx_bit, rx_line_err}, 4'b0010);
    rst_n = 1'b1;
    m_tx_last = 1'b0; m_tx_sent = 1'b0; m_pos = 0; m_neg = 0;
    m_rx_last = 1'b0; m_rx_seen = 1'b0; m_bit = 1; m_viol = 0; m_err = 0;
  endtask

  task automatic tx_cell(input logic v, input logic b, input logic f, input int gap);
    logic pol;
    tx_valid = v; tx_bit = b; tx_force_viol = f; tx_tick = 1'b1;
    #1 chk("R1 ready with tick", {3'b000, tx_ready}, 4'b0001);
    if (v && !b) begin
      pol = !m_tx_sent ? 1'b1 : (f ? m_tx_last : !m_tx_last);
      m_tx_last = pol; m_tx_sent = 1'b1; m_pos = pol; m_neg = !pol;
    end else begin
      m_pos = 0; m_neg = 0;
    end
    @(negedge clk);
    tx_tick = 1'b0;
    chk((v && !b) ? (f ? "R4 forced mark" : "R3 mark") : (v ? "R2 space" : "R5 idle"),
        {2'b00, line_pos_o, line_neg_o}, {2'b00, m_pos, m_neg});
    #1 chk("R1 ready low", {3'b000, tx_ready}, 4'b0000);
    for (int i = 0; i < gap; i++) begin
      tx_bit = $urandom; tx_valid = $urandom;
      @(negedge clk);
    end
    chk("R1 hold in cell", {2'b00, line_pos_o, line_neg_o}, {2'b00, m_pos, m_neg});
  endtask

  task automatic rx_cell(input logic p, input logic n, input int gap);
    rx_pos = p; rx_neg = n; rx_tick = 1'b1;
    if (p && n) begin
      m_bit = 0; m_viol = 0; m_err = 1;
    end else if (p ^ n) begin
      m_bit = 0; m_err = 0;
      m_viol = m_rx_seen && (p == m_rx_last);
      m_rx_last = p; m_rx_seen = 1'b1;
    end else begin
      m_bit = 1; m_viol = 0; m_err = 0;
    end
    @(negedge clk);
    rx_tick = 1'b0;
    chk((p && n) ? "R10 line error" : (m_viol ? "R8 violation" : "R7 decode"),
        {rx_valid, rx_bit, rx_viol, rx_line_err}, {1'b1, m_bit, m_viol, m_err});
    for (int i = 0; i < gap; i++) begin
      rx_pos = $urandom; rx_neg = $urandom;
      @(negedge clk);
    end
    if (gap > 0)
      chk("R8 flag held one cell", {rx_valid, rx_bit, rx_viol, rx_line_err},
          {1'b0, m_bit, m_viol, m_err});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    do_reset();
    // R4 forced on first mark: still positive; R3 alternation across ones
    tx_cell(1, 0, 1, 1);
    tx_cell(1, 1, 1, 0);
    tx_cell(0, 0, 0, 2);
    tx_cell(1, 0, 0, 0);
    tx_cell(1, 0, 1, 1);
    tx_cell(1, 0, 0, 0);
    // R9 first received mark negative, then repeat -> violation
    rx_cell(0, 1, 1);
    rx_cell(0, 1, 0);
    rx_cell(1, 1, 1);
    rx_cell(1, 0, 0);
    rx_cell(0, 0, 0);
    rx_cell(1, 0, 2);
    // second reset clears history (R9, R3)
    do_reset();
    rx_cell(1, 0, 0);
    tx_cell(1, 0, 0, 0);
    for (int k = 0; k < 400; k++) begin
      int r;
      r = $urandom_range(0, 9);
      tx_cell(r != 0, $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0,
              $urandom_range(0, 3));
      r = $urandom_range(0, 9);
      rx_cell(r < 4 || r == 9, (r >= 4 && r < 8) || r == 9, $urandom_range(0, 3));
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule